// File: doc/BRIEF.md
# Switch-Input Four-Function ALU

This block is a purely combinational arithmetic logic unit for two small unsigned or two's-complement operands. A 2-bit operation code chooses between addition, subtraction, bitwise AND and bitwise OR. It drives a result of the same width as the operands, plus three status flags: zero, carry and signed overflow. The default operand width is 3 bits.

The operand and operation inputs come straight from negative-logic switches. Each input pin therefore carries the ones' complement of its logical value, and the block inverts every input bit before using it. The outputs are active high.

The arithmetic path is a ripple chain of full-adder cells. Subtraction uses the same chain: the B operand is inverted and the chain's carry-in is set to 1. The carry output is therefore the raw carry leaving the chain, which is 1 when no borrow occurs. A 4:1 multiplexer picks the adder output or one of the bitwise results. The design has no clock, no storage and no procedural sequencing in the datapath.

Top module: `sw_alu`

## Requirements
- R1: Every bit of `a_sw_n`, `b_sw_n` and `op_sw_n` is inverted before use. After inversion the operation code means 00 = add, 01 = subtract, 10 = AND, 11 = OR. At the pins this is 11 = add, 10 = subtract, 01 = AND, 00 = OR.
- R2: For add, `res` equals (A + B) modulo 2^W.
- R3: For subtract, `res` equals (A - B) modulo 2^W, computed as A + ~B + 1.
- R4: For AND, `res` equals A & B; for OR, `res` equals A | B.
- R5: For every operation, `zero_flag` is 1 exactly when `res` is all zeros.
- R6: For add, `carry_flag` is bit W of the unsigned sum A + B. For subtract, `carry_flag` is 1 exactly when A >= B as unsigned values (no borrow).
- R7: For add and subtract, `ovf_flag` is 1 exactly when the two's-complement result falls outside the range -2^(W-1) to 2^(W-1)-1.
- R8: For AND and OR, `carry_flag` and `ovf_flag` are both 0.
- R9: The block is combinational, so every output reflects the current inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sw_n | input | DATA_W | Operand A, ones' complement of its logical value |
| b_sw_n | input | DATA_W | Operand B, ones' complement of its logical value |
| op_sw_n | input | 2 | Operation code, ones' complement of its logical value |
| res | output | DATA_W | Result of the selected operation |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out of the adder chain (no-borrow for subtract) |
| ovf_flag | output | 1 | Two's-complement overflow for add and subtract |

## Verification
Every result and flag is due in the same cycle as the stimulus: zero clock edges lie between an input change and the output that depends on it. The bench applies a new input set on a rising edge of its reference clock and samples all outputs on the following falling edge, once the combinational logic has settled. It then sweeps all 256 combinations of operands and operation code and compares each output against values computed with integer arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 2;

  // Internal (post-inversion) operation encoding
  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_fa.sv
module alu_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_s;

  assign half_s = x_i ^ y_i;
  assign s_o    = half_s ^ c_i;
  assign c_o    = (x_i & y_i) | (half_s & c_i);

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   chain;

  assign b_eff    = b_i ^ {W{sub_i}};
  assign chain[0] = sub_i;

  for (genvar k = 0; k < W; k++) begin : g_cell
    alu_fa fa_i (
      .x_i (a_i[k]),
      .y_i (b_eff[k]),
      .c_i (chain[k]),
      .s_o (sum_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign cout_o = chain[W];
  assign cmsb_o = chain[W-1];

  // Ripple chain agrees with wide arithmetic
  always_comb begin
    if (sub_i)
      AST_SUB_CHAIN: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1}))
        else $error("subtract chain mismatch"); // R3
    else
      AST_ADD_CHAIN: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("add chain mismatch"); // R2
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o
);

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign and_o[k] = a_i[k] & b_i[k];
    assign or_o[k]  = a_i[k] | b_i[k];
  end

endmodule

// File: rtl/alu_mux4.sv
module alu_mux4 #(
  parameter int W = 3
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  input  logic [W-1:0] d2_i,
  input  logic [W-1:0] d3_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] lo_pick;
  logic [W-1:0] hi_pick;

  assign lo_pick = sel_i[0] ? d1_i : d0_i;
  assign hi_pick = sel_i[0] ? d3_i : d2_i;
  assign q_o     = sel_i[1] ? hi_pick : lo_pick;

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 3
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  input  logic         cmsb_i,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic arith;

  assign arith   = is_arith(op_i);
  assign zero_o  = ~(|res_i);
  assign carry_o = arith & cout_i;
  assign ovf_o   = arith & (cmsb_i ^ cout_i);

endmodule

// File: rtl/sw_alu.sv
module sw_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic [DATA_W-1:0] a_sw_n,
  input  logic [DATA_W-1:0] b_sw_n,
  input  logic [OP_W-1:0]   op_sw_n,
  output logic [DATA_W-1:0] res,
  output logic              zero_flag,
  output logic              carry_flag,
  output logic              ovf_flag
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  alu_op_e           op_q;
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] and_w;
  logic [DATA_W-1:0] or_w;
  logic              cout_w;
  logic              cmsb_w;
  logic              sub_w;

  // Switch inputs are negative logic
  assign a_q   = ~a_sw_n;
  assign b_q   = ~b_sw_n;
  assign op_q  = alu_op_e'(~op_sw_n);
  assign sub_w = (op_q == OP_SUB);

  alu_addsub #(.W(DATA_W)) addsub_i (
    .a_i    (a_q),
    .b_i    (b_q),
    .sub_i  (sub_w),
    .sum_o  (sum_w),
    .cout_o (cout_w),
    .cmsb_o (cmsb_w)
  );

  alu_bitwise #(.W(DATA_W)) bitwise_i (
    .a_i   (a_q),
    .b_i   (b_q),
    .and_o (and_w),
    .or_o  (or_w)
  );

  alu_mux4 #(.W(DATA_W)) sel_i (
    .sel_i (op_q),
    .d0_i  (sum_w),
    .d1_i  (sum_w),
    .d2_i  (and_w),
    .d3_i  (or_w),
    .q_o   (res)
  );

  alu_flags #(.W(DATA_W)) flags_i (
    .op_i    (op_q),
    .res_i   (res),
    .cout_i  (cout_w),
    .cmsb_i  (cmsb_w),
    .zero_o  (zero_flag),
    .carry_o (carry_flag),
    .ovf_o   (ovf_flag)
  );

  // Output-level checks
  always_comb begin
    if (op_q == OP_AND)
      AST_AND_RESULT: assert (res == (a_q & b_q)) else $error("AND result"); // R4
    if (op_q == OP_OR)
      AST_OR_RESULT: assert (res == (a_q | b_q)) else $error("OR result"); // R4
    if (!is_arith(op_q))
      AST_LOGIC_FLAGS_CLEAR: assert (!carry_flag && !ovf_flag) else $error("logic flags"); // R8
    if (op_q == OP_SUB)
      AST_SUB_NO_BORROW: assert (carry_flag == (a_q >= b_q)) else $error("borrow"); // R6
    if (op_q == OP_ADD)
      AST_ADD_OVF_SIGN: assert (ovf_flag ==
        ((a_q[MSB] == b_q[MSB]) && (res[MSB] != a_q[MSB]))) else $error("add ovf"); // R7
    if (op_q == OP_SUB)
      AST_SUB_OVF_SIGN: assert (ovf_flag ==
        ((a_q[MSB] != b_q[MSB]) && (res[MSB] != a_q[MSB]))) else $error("sub ovf"); // R7
    AST_ZERO_ANY_OP: assert (zero_flag == (res == '0)) else $error("zero flag"); // R5
  end

endmodule

// File: tb/sw_alu_tb_top.sv
module sw_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 3;
  localparam int WDOG_LIMIT = 5000;

  logic         clk = 1'b0;
  logic [W-1:0] a_sw_n;
  logic [W-1:0] b_sw_n;
  logic [1:0]   op_sw_n;
  logic [W-1:0] res;
  logic         zero_flag;
  logic         carry_flag;
  logic         ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_alu #(.DATA_W(W)) dut_i (
    .a_sw_n     (a_sw_n),
    .b_sw_n     (b_sw_n),
    .op_sw_n    (op_sw_n),
    .res        (res),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive logical values through inverted pins (R1: op 0 add,1 sub,2 AND,3 OR)
  task automatic apply(input int a, input int b, input int op);
    @(posedge clk);
    a_sw_n  = ~W'(a);
    b_sw_n  = ~W'(b);
    op_sw_n = ~2'(op);
    @(negedge clk);
  endtask

  function automatic int sgn(input int v);
    return (v >= 4) ? v - 8 : v;
  endfunction

  task automatic check_all(input int a, input int b, input int op);
    int r, c, v, full;
    string tag;
    c = 0; v = 0;
    case (op)
      0: begin full = a + b; r = full & 7; c = (full >> 3) & 1;
               v = ((sgn(a) + sgn(b)) > 3 || (sgn(a) + sgn(b)) < -4) ? 1 : 0;
               tag = "R2"; end
      1: begin r = (a - b) & 7; c = (a >= b) ? 1 : 0;
               v = ((sgn(a) - sgn(b)) > 3 || (sgn(a) - sgn(b)) < -4) ? 1 : 0;
               tag = "R3"; end
      2: begin r = a & b; tag = "R4"; end
      default: begin r = a | b; tag = "R4"; end
    endcase
    check(tag, "res", int'(res), r);
    check("R5", "zero_flag", int'(zero_flag), (r == 0) ? 1 : 0);
    check((op < 2) ? "R6" : "R8", "carry_flag", int'(carry_flag), c);
    check((op < 2) ? "R7" : "R8", "ovf_flag", int'(ovf_flag), v);
  endtask

  // Fixed vectors: a, b, op, res, z, v, c
  task automatic vec(input int a, input int b, input int op,
                     input int r, input int z, input int v, input int c);
    apply(a, b, op);
    check("R9", "vec res", int'(res), r);
    check("R5", "vec zero", int'(zero_flag), z);
    check("R7", "vec ovf", int'(ovf_flag), v);
    check("R6", "vec carry", int'(carry_flag), c);
  endtask

  initial begin
    a_sw_n = '1; b_sw_n = '1; op_sw_n = '1;
    // R1: all pins high means A=0, B=0, add
    @(negedge clk);
    check("R1", "idle res", int'(res), 0);
    check("R1", "idle zero", int'(zero_flag), 1);
    check("R1", "idle carry", int'(carry_flag), 0);

    // R1: a pin pattern that only works with inversion (pins 110/100/10 -> 1 - 3 subtract)
    @(posedge clk);
    a_sw_n = 3'b110; b_sw_n = 3'b100; op_sw_n = 2'b10;
    @(negedge clk);
    check("R1", "inverted sub res", int'(res), 6);
    check("R1", "inverted sub carry", int'(carry_flag), 0);

    vec(1, 1, 0, 2, 0, 0, 0);
    vec(1, 1, 1, 0, 1, 0, 1);
    vec(1, 3, 0, 4, 0, 1, 0);
    vec(6, 3, 1, 3, 0, 1, 1);
    vec(1, 2, 2, 0, 1, 0, 0);
    vec(7, 7, 2, 7, 0, 0, 0);
    vec(0, 0, 3, 0, 1, 0, 0);
    vec(3, 5, 3, 7, 0, 0, 0);

    // Exhaustive sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          apply(a, b, op);
          check_all(a, b, op);
        end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule